// File: doc/BRIEF.md
# Asynchronous static RAM access controller

This block sits between a clocked request port and an untimed static RAM chip. A client presents a request with a valid strobe, a write flag, an address and write data. The controller then steps the memory through a fixed series of phases, each a whole number of clock cycles long. Every phase drives active-low chip select, output enable and write enable and one shared tri-state data bus. Each access ends with a one-cycle done pulse. For a read, the captured data comes out with that pulse.

A write first sets up the address for one cycle with chip select low. It then pulses write enable low for `WE_CYCLES` cycles while the controller drives the data. A final hold cycle follows, in which write enable is high again and address and data are still held, so the memory latches on the trailing edge of write enable combined with chip select. A read keeps output enable low for `RD_CYCLES` cycles and samples the bus at the end of the last one. It then spends one turnaround cycle with output enable high and the bus released. The client may only start a request while `req_ready` is high.

Top module: `sram_async_ctrl`

## Requirements
- R1: While reset is held, mem_cs_n, mem_oe_n and mem_we_n are 1, rsp_done is 0 and req_ready is 1.
- R2: A write holds mem_cs_n at 0 for exactly WE_CYCLES+2 cycles. mem_we_n is 1 in the first cycle, 0 for the next WE_CYCLES cycles, and 1 in the last cycle.
- R3: mem_addr equals the address accepted with the request and stays unchanged for every cycle in which mem_cs_n is 0.
- R4: During every write cycle with mem_cs_n at 0, mem_data carries the accepted write data. The memory therefore stores it on the rising edge of (mem_we_n OR mem_cs_n).
- R5: A read holds mem_cs_n and mem_oe_n at 0 for RD_CYCLES cycles, followed by one cycle with mem_cs_n 0 and mem_oe_n 1. rsp_rdata presents the bus value sampled at the end of the last output-enable cycle.
- R6: The controller never drives mem_data while mem_oe_n is 0, and mem_oe_n and mem_we_n are never 0 together.
- R7: After mem_oe_n rises, the controller drives mem_data no earlier than two cycles later. These are the turnaround cycle and the idle cycle.
- R8: req_ready is 1 only in the idle phase. A request is taken only in a cycle with req_ready at 1. A request presented while req_ready is 0 has no effect.
- R9: rsp_done is a single-cycle pulse. For a write it comes in the first idle cycle after the hold cycle. For a read it comes in the turnaround cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request strobe |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW | Request address |
| req_wdata | input | DW | Write data |
| req_ready | output | 1 | Controller idle, a request will be taken |
| rsp_done | output | 1 | Access complete pulse |
| rsp_rdata | output | DW | Read data, valid with rsp_done after a read |
| mem_addr | output | AW | Memory address |
| mem_cs_n | output | 1 | Chip select, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_data | inout | DW | Shared bidirectional data bus |

## Verification
Two events can fall in the same cycle. After a write, the done pulse shares its cycle with the idle phase, so a new request can be accepted in the very cycle the previous one reports completion. After a read, the done pulse falls in the turnaround cycle, where a waiting request must still be refused. The bench provokes both cases by holding req_valid high, with the address, data and direction changing every cycle. A reference model then accepts only in the cycles it predicts as ready. Each cycle it compares the strobes, the address, the driven data and the read data.

// File: rtl/sram_async_ctrl.sv
module sram_async_ctrl #(
  parameter int AW = 16,
  parameter int DW = 16,
  parameter int WE_CYCLES = 2,
  parameter int RD_CYCLES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic          req_write,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  output logic          req_ready,
  output logic          rsp_done,
  output logic [DW-1:0] rsp_rdata,
  output logic [AW-1:0] mem_addr,
  output logic          mem_cs_n,
  output logic          mem_oe_n,
  output logic          mem_we_n,
  inout  wire  [DW-1:0] mem_data
);
  localparam int MAXC = (WE_CYCLES > RD_CYCLES) ? WE_CYCLES : RD_CYCLES;
  localparam int CW = (MAXC > 1) ? $clog2(MAXC) : 1;
  localparam logic [CW-1:0] WE_LAST = CW'(WE_CYCLES - 1);
  localparam logic [CW-1:0] RD_LAST = CW'(RD_CYCLES - 1);

  typedef enum logic [2:0] {IDLE, W_SETUP, W_PULSE, W_HOLD, R_ACC, R_TURN} phase_t;

  phase_t        st;
  logic [CW-1:0] cnt;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] wdata_q, rdata_q;
  logic          done_q;
  logic          drv;

  assign req_ready = (st == IDLE);
  assign mem_cs_n  = (st == IDLE);
  assign mem_oe_n  = (st != R_ACC);
  assign mem_we_n  = (st != W_PULSE);
  assign drv       = (st == W_SETUP) || (st == W_PULSE) || (st == W_HOLD);
  assign mem_data  = drv ? wdata_q : {DW{1'bz}};
  assign mem_addr  = addr_q;
  assign rsp_done  = done_q;
  assign rsp_rdata = rdata_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= IDLE;
      cnt     <= '0;
      addr_q  <= '0;
      wdata_q <= '0;
      rdata_q <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (st)
        IDLE: if (req_valid) begin
          addr_q  <= req_addr;
          wdata_q <= req_wdata;
          cnt     <= '0;
          st      <= req_write ? W_SETUP : R_ACC;
        end
        W_SETUP: st <= W_PULSE;
        W_PULSE: if (cnt == WE_LAST) st <= W_HOLD;
                 else cnt <= cnt + 1'b1;
        W_HOLD: begin
          st     <= IDLE;
          done_q <= 1'b1;
        end
        R_ACC: if (cnt == RD_LAST) begin
          rdata_q <= mem_data;
          done_q  <= 1'b1;
          st      <= R_TURN;
        end else cnt <= cnt + 1'b1;
        R_TURN: st <= IDLE;
        default: st <= IDLE;
      endcase
    end
  end

  assert_addr_stable_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_cs_n && $past(!mem_cs_n)) |-> $stable(mem_addr));
  assert_we_setup_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_we_n) |-> ($past(mem_cs_n) == 1'b0));
  assert_we_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_n) |-> !mem_cs_n);
  assert_no_drive_on_read_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_oe_n |-> (!drv && mem_we_n));
  assert_turnaround_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_oe_n) |=> !drv);
  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |=> !rsp_done);
  assert_busy_ignore_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !req_ready |=> $stable(mem_addr));
endmodule

// File: tb/sim_sram_async_ctrl.sv
module sim_sram_async_ctrl;
  localparam int AW = 16, DW = 16, WEC = 2, RDC = 2;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_write = 0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic req_ready, rsp_done, mem_cs_n, mem_oe_n, mem_we_n;
  logic [DW-1:0] rsp_rdata;
  logic [AW-1:0] mem_addr;
  wire  [DW-1:0] bus;

  int checks = 0, errors = 0, cycles = 0;

  always #10 clk = ~clk;

  sram_async_ctrl #(.AW(AW), .DW(DW), .WE_CYCLES(WEC), .RD_CYCLES(RDC)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready),
    .rsp_done(rsp_done), .rsp_rdata(rsp_rdata), .mem_addr(mem_addr),
    .mem_cs_n(mem_cs_n), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n), .mem_data(bus));

  logic [DW-1:0] sram [16];
  logic [DW-1:0] shadow [16];
  wire sram_drv = !mem_cs_n && !mem_oe_n && mem_we_n;
  assign bus = sram_drv ? sram[mem_addr[3:0]] : {DW{1'bz}};
  wire wecs = mem_we_n | mem_cs_n;
  always @(posedge wecs) sram[mem_addr[3:0]] <= bus;

  // entry: {rd_done, ready, cs_n, oe_n, we_n, drv, done}
  localparam logic [6:0] IDLE_V = 7'b0111100;
  logic [6:0] q[$];
  logic [AW-1:0] exp_addr = '0;
  logic [DW-1:0] exp_wdata = '0, exp_rd = '0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s: actual %h expected %h at cycle %0d", tag, act, expv, cycles);
    end
  endtask

  always @(posedge clk) begin
    logic [6:0] cur;
    logic acc;
    cycles++;
    if (rst_n) begin
      cur = (q.size() != 0) ? q[0] : IDLE_V;
      acc = cur[5] && req_valid;
      if (q.size() != 0) void'(q.pop_front());
      if (acc) begin
        exp_addr = req_addr;
        if (req_write) begin
          exp_wdata = req_wdata;
          shadow[req_addr[3:0]] = req_wdata;
          q.push_back(7'b0001110);
          for (int i = 0; i < WEC; i++) q.push_back(7'b0001010);
          q.push_back(7'b0001110);
          q.push_back(7'b0111101);
        end else begin
          exp_rd = shadow[req_addr[3:0]];
          for (int i = 0; i < RDC; i++) q.push_back(7'b0000100);
          q.push_back(7'b1001101);
        end
      end
    end
  end

  always @(negedge clk) begin
    logic [6:0] cur;
    if (rst_n) begin
      cur = (q.size() != 0) ? q[0] : IDLE_V;
      chk("R8 ready", 32'(req_ready), 32'(cur[5]));
      chk("R2 cs_n", 32'(mem_cs_n), 32'(cur[4]));
      chk("R5 oe_n", 32'(mem_oe_n), 32'(cur[3]));
      chk("R2 we_n", 32'(mem_we_n), 32'(cur[2]));
      chk("R9 done", 32'(rsp_done), 32'(cur[0]));
      if (!cur[4]) chk("R3 addr", 32'(mem_addr), 32'(exp_addr));
      if (cur[1]) chk("R4 wdata", 32'(bus), 32'(exp_wdata));
      if (!cur[3]) chk("R6 bus", 32'(bus), 32'(sram[mem_addr[3:0]]));
      if (cur[6]) chk("R5 rdata", 32'(rsp_rdata), 32'(exp_rd));
    end
  end

  task automatic req(input logic w, input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1; req_write = w; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 0;
  endtask

  initial begin
    for (int i = 0; i < 16; i++) begin sram[i] = '0; shadow[i] = '0; end
    #5;
    chk("R1 cs_n", 32'(mem_cs_n), 1);
    chk("R1 oe_n", 32'(mem_oe_n), 1);
    chk("R1 we_n", 32'(mem_we_n), 1);
    chk("R1 done", 32'(rsp_done), 0);
    chk("R1 ready", 32'(req_ready), 1);
    repeat (3) @(negedge clk);
    rst_n = 1;
    req(1, 16'h0003, 16'hA5A5);
    req(1, 16'h000C, 16'h1234);
    req(0, 16'h0003, 16'h0000);
    req(0, 16'h000C, 16'h0000);
    req(1, 16'h0003, 16'hFFFF);
    req(0, 16'h0003, 16'h0000);
    repeat (8) @(negedge clk);
    for (int i = 0; i < 300; i++) begin
      req_valid = 1;
      req_write = (i % 3) != 1;
      req_addr  = AW'(i % 16);
      req_wdata = DW'(i * 16'h0101 + 7);
      @(negedge clk);
    end
    req_valid = 0;
    repeat (10) @(negedge clk);
    for (int i = 0; i < 16; i++) req(0, AW'(i), '0);
    repeat (10) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #2000000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule